// File: doc/BRIEF.md
# Asynchronous Memory Read Cycle Engine

This block performs single read accesses to an external asynchronous device, such as a static RAM or a character display module, and runs entirely on one master clock. A start request latches an address, a capture-mode bit and six timing values. The block then drives the address bus and two active-low strobes: a device select and a read enable. When the chosen capture point arrives, it samples the external data bus. The captured byte is presented with a one-clock done pulse.

The two strobes are timed independently. Each one has a setup count (cycles before it falls), a pulse count (cycles it stays low) and a cycle count. The access lasts as long as the largest of the two cycle counts and the two setup-plus-pulse spans, and the address stays on the bus for that whole time. The capture-mode bit alone decides where data is taken. When it is 1, data is captured on the clock edge that raises the read enable. When it is 0, data is captured on the edge that raises the device select. The block never compares the two waveforms against each other.

The controller has two states. `ST_IDLE` waits for a request. A request in `ST_IDLE` takes the *launch* transition to `ST_ACCESS`. `ST_ACCESS` counts access cycles and stays put (*dwell*) until the last cycle of the access. From there it takes the *retire* transition back to `ST_IDLE`.

Top module: `async_read_engine`

## Requirements
- R1: After reset, both strobes are high, done and busy are low and the captured byte is 0.
- R2: The address is latched on the launch edge and held on `addr_o` for the whole access. Busy stays high for exactly L cycles, where L is the largest of the select cycle count, the enable cycle count, select setup plus pulse, and enable setup plus pulse.
- R3: Access cycle k=0 is the first cycle after the launch edge. The device select is low in access cycles k where setup <= k < setup+pulse, and high in all other cycles.
- R4: The read enable follows the same rule as R3, using its own setup and pulse counts.
- R5: A pulse count of 0 is treated as 1, so the strobe is low for exactly one cycle.
- R6: With `rd_edge_sel_i`=1, the captured byte is the value of `data_i` at the clock edge that raises the read enable. The device-select waveform has no effect on this.
- R7: With `rd_edge_sel_i`=0, the captured byte is the value of `data_i` at the clock edge that raises the device select. The read-enable waveform has no effect on this.
- R8: Done is high for exactly one cycle, in the cycle right after the capture edge. `data_o` changes only in that cycle.
- R9: A start request made while busy is high is ignored. The address does not change and no extra done pulse appears.
- R10: While the engine is idle, both strobes are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Read request, accepted only while idle |
| addr_i | input | 24 | Address for the request |
| rd_edge_sel_i | input | 1 | Capture point: 1 = read-enable rise, 0 = device-select rise |
| cs_setup_i | input | 6 | Device-select setup count |
| cs_pulse_i | input | 6 | Device-select pulse count (0 treated as 1) |
| cs_cycle_i | input | 6 | Device-select cycle count |
| re_setup_i | input | 6 | Read-enable setup count |
| re_pulse_i | input | 6 | Read-enable pulse count (0 treated as 1) |
| re_cycle_i | input | 6 | Read-enable cycle count |
| data_i | input | 8 | External data bus |
| addr_o | output | 24 | External address bus |
| cs_n_o | output | 1 | Device select, active low |
| re_n_o | output | 1 | Read enable, active low |
| data_o | output | 8 | Captured byte |
| done_o | output | 1 | One-cycle capture-complete pulse |
| busy_o | output | 1 | Access in progress |

## Verification
The hardest case to bring about is proving that the capture point follows the mode bit and not whichever strobe rises first. If the data bus were held constant, every capture point would return the same byte. The bench therefore changes `data_i` on every clock, so each byte identifies the edge that sampled it. It then runs timings where the unselected strobe rises both before and after the selected one. A second hard case is a request made during an access: the stimulus raises start in the middle of long accesses with a different address, and then checks that the address bus is unchanged and that no extra done pulse appears.

// File: rtl/async_read_engine_pkg.sv
package async_read_engine_pkg;
    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_ACCESS = 1'b1
    } rd_state_e;

    localparam int STROBES = 2;
    localparam int SEL_CS  = 0;
    localparam int SEL_RE  = 1;
endpackage

// File: rtl/strobe_timer.sv
module strobe_timer #(
    parameter int CNT_W = 6,
    localparam int KW = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             nxt_valid,
    input  logic [KW-1:0]    nxt_k,
    input  logic             cur_valid,
    input  logic [KW-1:0]    cur_k,
    input  logic [CNT_W-1:0] setup,
    input  logic [CNT_W-1:0] pulse,
    output logic             strobe_n,
    output logic             last_low,
    output logic [KW-1:0]    span
);
    logic [KW-1:0] lo_k;
    logic [KW-1:0] width_k;
    logic          low_next;

    // zero pulse is clamped to a single cycle
    assign width_k  = (pulse == '0) ? KW'(1) : KW'(pulse);
    assign lo_k     = KW'(setup);
    assign span     = lo_k + width_k;
    assign low_next = nxt_valid && (nxt_k >= lo_k) && (nxt_k < span);
    assign last_low = cur_valid && (cur_k == span - KW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) strobe_n <= 1'b1;
        else        strobe_n <= !low_next;
    end
endmodule

// File: rtl/step_counter.sv
module step_counter #(
    parameter int KW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          adv,
    output logic [KW-1:0] k_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     k_q <= '0;
        else if (clear) k_q <= '0;
        else if (adv)   k_q <= k_q + KW'(1);
    end
endmodule

// File: rtl/async_read_engine.sv
module async_read_engine #(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_edge_sel_i,
    input  logic [CNT_W-1:0]  cs_setup_i,
    input  logic [CNT_W-1:0]  cs_pulse_i,
    input  logic [CNT_W-1:0]  cs_cycle_i,
    input  logic [CNT_W-1:0]  re_setup_i,
    input  logic [CNT_W-1:0]  re_pulse_i,
    input  logic [CNT_W-1:0]  re_cycle_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              cs_n_o,
    output logic              re_n_o,
    output logic [DATA_W-1:0] data_o,
    output logic              done_o,
    output logic              busy_o
);
    import async_read_engine_pkg::*;

    localparam int KW = CNT_W + 1;

    rd_state_e        state_q, state_d;
    logic             launch;
    logic             at_end;
    logic             capture;
    logic             mode_q;
    logic [KW-1:0]    k_q;
    logic [KW-1:0]    len_e;
    logic             nxt_valid;
    logic [KW-1:0]    nxt_k;

    logic [CNT_W-1:0] setup_in [STROBES];
    logic [CNT_W-1:0] pulse_in [STROBES];
    logic [CNT_W-1:0] cycle_in [STROBES];
    logic [CNT_W-1:0] setup_q  [STROBES];
    logic [CNT_W-1:0] pulse_q  [STROBES];
    logic [CNT_W-1:0] cycle_q  [STROBES];
    logic [CNT_W-1:0] setup_e  [STROBES];
    logic [CNT_W-1:0] pulse_e  [STROBES];
    logic [CNT_W-1:0] cycle_e  [STROBES];
    logic             strobe_n [STROBES];
    logic             last_low [STROBES];
    logic [KW-1:0]    span     [STROBES];

    assign setup_in[SEL_CS] = cs_setup_i;
    assign pulse_in[SEL_CS] = cs_pulse_i;
    assign cycle_in[SEL_CS] = cs_cycle_i;
    assign setup_in[SEL_RE] = re_setup_i;
    assign pulse_in[SEL_RE] = re_pulse_i;
    assign cycle_in[SEL_RE] = re_cycle_i;

    assign launch = (state_q == ST_IDLE) && start_i;

    // timing settings: live while idle, frozen during an access
    for (genvar s = 0; s < STROBES; s++) begin : g_strobe
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                setup_q[s] <= '0;
                pulse_q[s] <= '0;
                cycle_q[s] <= '0;
            end else if (launch) begin
                setup_q[s] <= setup_in[s];
                pulse_q[s] <= pulse_in[s];
                cycle_q[s] <= cycle_in[s];
            end
        end

        assign setup_e[s] = (state_q == ST_IDLE) ? setup_in[s] : setup_q[s];
        assign pulse_e[s] = (state_q == ST_IDLE) ? pulse_in[s] : pulse_q[s];
        assign cycle_e[s] = (state_q == ST_IDLE) ? cycle_in[s] : cycle_q[s];

        strobe_timer #(.CNT_W(CNT_W)) u_timer (
            .clk       (clk),
            .rst_n     (rst_n),
            .nxt_valid (nxt_valid),
            .nxt_k     (nxt_k),
            .cur_valid (state_q == ST_ACCESS),
            .cur_k     (k_q),
            .setup     (setup_e[s]),
            .pulse     (pulse_e[s]),
            .strobe_n  (strobe_n[s]),
            .last_low  (last_low[s]),
            .span      (span[s])
        );
    end

    // access length: longest of both cycle counts and both strobe spans
    always_comb begin
        len_e = KW'(cycle_e[SEL_CS]);
        if (KW'(cycle_e[SEL_RE]) > len_e) len_e = KW'(cycle_e[SEL_RE]);
        if (span[SEL_CS] > len_e)         len_e = span[SEL_CS];
        if (span[SEL_RE] > len_e)         len_e = span[SEL_RE];
    end

    assign at_end = (k_q == len_e - KW'(1));

    step_counter #(.KW(KW)) u_steps (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (launch),
        .adv   ((state_q == ST_ACCESS) && !at_end),
        .k_q   (k_q)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and next access step
    always_comb begin
        state_d   = state_q;
        nxt_valid = 1'b0;
        nxt_k     = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin           // launch
                    state_d   = ST_ACCESS;
                    nxt_valid = 1'b1;
                end
            end
            ST_ACCESS: begin
                if (at_end) begin            // retire
                    state_d = ST_IDLE;
                end else begin               // dwell
                    nxt_valid = 1'b1;
                    nxt_k     = k_q + KW'(1);
                end
            end
        endcase
    end

    assign capture = (state_q == ST_ACCESS) &&
                     (mode_q ? last_low[SEL_RE] : last_low[SEL_CS]);

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_o <= '0;
            mode_q <= 1'b0;
            data_o <= '0;
            done_o <= 1'b0;
        end else begin
            if (launch) begin
                addr_o <= addr_i;
                mode_q <= rd_edge_sel_i;
            end
            if (capture) data_o <= data_i;
            done_o <= capture;
        end
    end

    assign cs_n_o = strobe_n[SEL_CS];
    assign re_n_o = strobe_n[SEL_RE];
    assign busy_o = (state_q == ST_ACCESS);

    assert_idle_strobes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (cs_n_o && re_n_o));

    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_data_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_o != $past(data_o)) |-> done_o);

    assert_busy_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(addr_o));

    // covers R7 as well: the selected strobe rose at the capture edge
    assert_capture_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (mode_q ? $rose(re_n_o) : $rose(cs_n_o)));
endmodule

// File: tb/test_async_read_engine.sv
module test_async_read_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [23:0] addr_i = '0;
    logic        rd_edge_sel_i = 1'b0;
    logic [5:0]  cs_setup_i = '0, cs_pulse_i = '0, cs_cycle_i = '0;
    logic [5:0]  re_setup_i = '0, re_pulse_i = '0, re_cycle_i = '0;
    logic [7:0]  data_i = '0;
    logic [23:0] addr_o;
    logic        cs_n_o, re_n_o, done_o, busy_o;
    logic [7:0]  data_o;

    always #5 clk = ~clk;

    async_read_engine i_async_read_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
        .rd_edge_sel_i(rd_edge_sel_i),
        .cs_setup_i(cs_setup_i), .cs_pulse_i(cs_pulse_i), .cs_cycle_i(cs_cycle_i),
        .re_setup_i(re_setup_i), .re_pulse_i(re_pulse_i), .re_cycle_i(re_cycle_i),
        .data_i(data_i), .addr_o(addr_o), .cs_n_o(cs_n_o), .re_n_o(re_n_o),
        .data_o(data_o), .done_o(done_o), .busy_o(busy_o)
    );

    typedef struct {
        int          tick;
        logic [7:0]  data;
        logic [23:0] addr;
        string       req;
    } exp_t;

    exp_t sb[$];
    int   n_chk = 0;
    int   n_fail = 0;
    int   tick = 0;
    logic prev_done = 1'b0;
    logic [7:0] last_data = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // monitor: pops expected captures as done pulses appear
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_o) begin
                check(!prev_done, "R8", "done longer than one cycle", 1, 0);
                if (sb.size() == 0) begin
                    check(1'b0, "R9", "unexpected done pulse", 1, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(tick == e.tick, "R8", "done cycle", tick, e.tick);
                    check(data_o == e.data, e.req, "captured byte", data_o, e.data);
                    check(addr_o == e.addr, "R2", "address at done", addr_o, e.addr);
                end
            end else begin
                if (sb.size() > 0 && tick > sb[0].tick) begin
                    exp_t e;
                    e = sb.pop_front();
                    check(1'b0, "R8", "missing done pulse", tick, e.tick);
                end
                if (data_o != last_data)
                    check(1'b0, "R8", "byte changed without done", data_o, last_data);
            end
            prev_done = done_o;
            last_data = data_o;
        end
        tick++;
        data_i = 8'(tick);
    end

    task automatic run_read(input logic [23:0] addr, input bit mode,
                            input int css, input int csp, input int csc,
                            input int res, input int rep, input int rec,
                            input bit inject);
        int cs_pe, re_pe, cs_hi, re_hi, len, kc, t;
        int cs_first, cs_cnt, re_first, re_cnt, busy_cnt, k;
        bit addr_ok, idle_ok;
        exp_t e;
        cs_pe = (csp == 0) ? 1 : csp;
        re_pe = (rep == 0) ? 1 : rep;
        cs_hi = css + cs_pe;
        re_hi = res + re_pe;
        len = csc;
        if (rec > len) len = rec;
        if (cs_hi > len) len = cs_hi;
        if (re_hi > len) len = re_hi;
        kc = mode ? re_hi - 1 : cs_hi - 1;

        @(posedge clk); #1;
        addr_i = addr; rd_edge_sel_i = mode;
        cs_setup_i = 6'(css); cs_pulse_i = 6'(csp); cs_cycle_i = 6'(csc);
        re_setup_i = 6'(res); re_pulse_i = 6'(rep); re_cycle_i = 6'(rec);
        start_i = 1'b1;
        t = tick;
        e.tick = t + 2 + kc;
        e.data = 8'(t + 2 + kc);
        e.addr = addr;
        e.req = mode ? "R6" : "R7";
        sb.push_back(e);
        @(posedge clk); #1;
        start_i = 1'b0;

        cs_first = -1; re_first = -1; cs_cnt = 0; re_cnt = 0; busy_cnt = 0;
        addr_ok = 1'b1; k = 0;
        while (busy_o) begin
            busy_cnt++;
            if (!cs_n_o) begin cs_cnt++; if (cs_first < 0) cs_first = k; end
            if (!re_n_o) begin re_cnt++; if (re_first < 0) re_first = k; end
            if (addr_o != addr) addr_ok = 1'b0;
            if (inject && k == 1) begin start_i = 1'b1; addr_i = ~addr; end
            if (k == 2) start_i = 1'b0;
            k++;
            @(posedge clk); #1;
        end
        start_i = 1'b0;
        idle_ok = cs_n_o && re_n_o;

        check(busy_cnt == len, "R2", "busy cycles", busy_cnt, len);
        check(addr_ok, inject ? "R9" : "R2", "address held during access", addr_o, addr);
        check(cs_first == css, "R3", "select fall cycle", cs_first, css);
        check(cs_cnt == cs_pe, (csp == 0) ? "R5" : "R3", "select low cycles", cs_cnt, cs_pe);
        check(re_first == res, "R4", "enable fall cycle", re_first, res);
        check(re_cnt == re_pe, (rep == 0) ? "R5" : "R4", "enable low cycles", re_cnt, re_pe);
        check(idle_ok, "R10", "strobes high when idle", {cs_n_o, re_n_o}, 3);
        repeat (3) @(posedge clk);
        #1;
        check(sb.size() == 0, "R8", "pending captures", sb.size(), 0);
        check(addr_o == addr, "R9", "address after access", addr_o, addr);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(cs_n_o && re_n_o, "R1", "strobes in reset", {cs_n_o, re_n_o}, 3);
        check(!done_o && !busy_o, "R1", "done/busy in reset", {done_o, busy_o}, 0);
        check(data_o == 8'h00, "R1", "byte in reset", data_o, 0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);

        // R6: enable rises before select, capture on enable
        run_read(24'h12_3456, 1'b1, 0, 4, 6, 1, 2, 6, 1'b0);
        // R7: same waveforms, capture on select
        run_read(24'hAB_CDEF, 1'b0, 0, 4, 6, 1, 2, 6, 1'b0);
        // R6: enable rises after select
        run_read(24'h00_0F0F, 1'b1, 1, 1, 5, 0, 4, 5, 1'b0);
        // R7: select rises after enable
        run_read(24'hF0_0000, 1'b0, 0, 5, 8, 2, 1, 8, 1'b0);
        // R5: zero pulses clamped
        run_read(24'h55_AA55, 1'b1, 2, 0, 4, 1, 0, 4, 1'b0);
        run_read(24'h55_AA56, 1'b0, 0, 0, 2, 3, 0, 1, 1'b0);
        // R2: cycle count longer than both strobes
        run_read(24'h0A_0B0C, 1'b0, 0, 1, 10, 0, 1, 3, 1'b0);
        // R9: requests during an access
        run_read(24'h33_4455, 1'b1, 0, 3, 6, 1, 2, 5, 1'b1);
        run_read(24'h77_8899, 1'b0, 2, 6, 12, 0, 1, 12, 1'b1);
        // shortest access
        run_read(24'h00_0001, 1'b0, 0, 1, 1, 0, 1, 1, 1'b0);
        run_read(24'h00_0002, 1'b1, 0, 1, 0, 0, 1, 0, 1'b0);
        // largest counts
        run_read(24'hFF_FFFF, 1'b1, 60, 3, 63, 62, 1, 63, 1'b0);
        for (int i = 0; i < 6; i++)
            run_read(24'(i * 24'h01_1111), 1'(i % 2), i, i % 3, 2 * i, 5 - i, (i + 1) % 3, i + 1, 1'(i > 2));

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule